// File: doc/BRIEF.md
# Dual-Mode Raster Sync Generator

This block produces the line and frame timing for a 640-pixel-wide monochrome raster display. A free-running prescaler divides the fast system clock by four to make a pixel-rate enable. A pixel counter steps on every enable and spans 800 pixel slots per line. A line counter steps once per line and wraps at the frame total. From these two counters the block derives horizontal sync, vertical sync, a flag for visible lines, the current line number, and one-cycle strobes at the start of each line and each frame.

A static mode input picks one of two frame geometries. Mode 0 has 525 lines, 480 of them visible, and an active-low vertical pulse. Mode 1 has 445 lines, 400 of them visible, and an active-high vertical pulse. The mode input is only taken in at a frame boundary, so a change made in mid-frame waits until the current frame has ended. The horizontal pulse sits early in the line count and is the same in both modes. A pixel source downstream uses the strobes and the line number to fetch its data.

Top module: `vgaSyncGen`

## Requirements
- R1: A line lasts DIV*H_TOTAL system clocks (defaults 4 and 800). `lineStart` is high for exactly one system clock on the clock edge where the pixel count wraps from H_TOTAL-1 to 0.
- R2: `hsync` is low while the pixel count is in [HS_START, HS_END), which is [16, 48) by default, and high at every other pixel count.
- R3: In mode 0 (`modeSel`=0), the frame has 525 lines, and vertical sync is active for lines 490 and 491, that is [490, 492).
- R4: In mode 1 (`modeSel`=1), the frame has 445 lines, and vertical sync is active for lines 401 to 403, that is [401, 404).
- R5: `vsync` is low when active in mode 0 and high when active in mode 1. It rests at the opposite level when inactive.
- R6: The pixel count advances only on one system clock out of every DIV, and the first advance after reset comes on the DIV-th clock edge.
- R7: `lineNum` advances by one on each `lineStart`. It wraps to 0 after the last line of the frame. `frameStart` is high, together with `lineStart`, only on the wrap from the last line.
- R8: `modeSel` takes effect only on the `frameStart` edge. A change in mid-frame does not alter the frame total, the sync window or the polarity of the frame in progress.
- R9: While reset (`rst`, synchronous, active high) is held, `lineNum` is 0, both strobes are low, `hsync` is high, and `vsync` sits at the inactive level of the mode present on `modeSel` during reset.
- R10: `lineVisible` is high exactly for lines below the visible count of the current frame's mode: 480 in mode 0 and 400 in mode 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| modeSel | input | 1 | Geometry select: 0 = 480 visible lines, 1 = 400 visible lines |
| hsync | output | 1 | Horizontal sync, active low |
| vsync | output | 1 | Vertical sync, with its polarity set by the mode |
| lineVisible | output | 1 | High while the current line is visible |
| lineNum | output | LW (10) | Current line number within the frame |
| lineStart | output | 1 | One-clock strobe at the wrap of the pixel count |
| frameStart | output | 1 | One-clock strobe at the wrap of the line count |

## Verification
The assertions assume that reset is held for at least two clocks. They also assume that `modeSel` does not change during reset, so the stored mode is settled before checking starts. The stimulus holds `modeSel` constant through every reset and changes it only between resets. The changes fall at points away from frame boundaries, and some land near one, so the mode switch at a boundary is exercised. The bench uses a reduced geometry so that full frames fit in the run, with expected outputs computed from counter arithmetic.

// File: rtl/vgaSyncPkg.sv
package vgaSyncPkg;
  // Frame geometry selector: 0 = tall (480 visible), 1 = short (400 visible)
  typedef enum logic {
    MODE_TALL  = 1'b0,
    MODE_SHORT = 1'b1
  } scanMode_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic pixEn;     // pixel-rate enable
    logic lineWrap;  // pixel count wraps this cycle
    logic frameWrap; // line count wraps this cycle
  } timingStrobes_t;
endpackage

// File: rtl/vgaSyncCtrl.sv
module vgaSyncCtrl
  import vgaSyncPkg::*;
#(
  parameter int DIV = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hAtEnd,
  input  logic           vAtEnd,
  output timingStrobes_t strobes
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(DIV - 1);

  logic [DW-1:0] divCnt;

  generate
    if (DIV > 1) begin : gen_prescale
      always_ff @(posedge clk) begin
        if (rst)                   divCnt <= '0;
        else if (divCnt == DIV_LAST) divCnt <= '0;
        else                       divCnt <= divCnt + 1'b1;
      end
    end else begin : gen_noprescale
      always_ff @(posedge clk) divCnt <= '0;
    end
  endgenerate

  always_comb begin
    strobes.pixEn     = !rst && (divCnt == DIV_LAST);
    strobes.lineWrap  = strobes.pixEn && hAtEnd;
    strobes.frameWrap = strobes.lineWrap && vAtEnd;
  end
endmodule

// File: rtl/vgaSyncDatapath.sv
module vgaSyncDatapath
  import vgaSyncPkg::*;
#(
  parameter int H_TOTAL    = 800,
  parameter int HS_START   = 16,
  parameter int HS_END     = 48,
  parameter int A_VTOTAL   = 525,
  parameter int A_VISIBLE  = 480,
  parameter int A_VS_START = 490,
  parameter int A_VS_END   = 492,
  parameter int B_VTOTAL   = 445,
  parameter int B_VISIBLE  = 400,
  parameter int B_VS_START = 401,
  parameter int B_VS_END   = 404,
  parameter int LW         = 10,
  localparam int HW        = $clog2(H_TOTAL)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           modeSel,
  input  timingStrobes_t strobes,
  output logic [HW-1:0]  hCount,
  output logic [LW-1:0]  lineNum,
  output scanMode_t      activeMode,
  output logic           hAtEnd,
  output logic           vAtEnd,
  output logic           hsync,
  output logic           vsync,
  output logic           lineVisible
);
  localparam logic [HW-1:0] H_LAST   = HW'(H_TOTAL - 1);
  localparam logic [HW-1:0] H_SYNC_A = HW'(HS_START);
  localparam logic [HW-1:0] H_SYNC_B = HW'(HS_END);

  localparam logic [LW-1:0] A_LAST = LW'(A_VTOTAL - 1);
  localparam logic [LW-1:0] A_VIS  = LW'(A_VISIBLE);
  localparam logic [LW-1:0] A_VSA  = LW'(A_VS_START);
  localparam logic [LW-1:0] A_VSB  = LW'(A_VS_END);
  localparam logic [LW-1:0] B_LAST = LW'(B_VTOTAL - 1);
  localparam logic [LW-1:0] B_VIS  = LW'(B_VISIBLE);
  localparam logic [LW-1:0] B_VSA  = LW'(B_VS_START);
  localparam logic [LW-1:0] B_VSB  = LW'(B_VS_END);

  logic [LW-1:0] lastLine, visLines, vsFrom, vsTo;
  logic          vsPolHigh, vsActive;

  // Pixel counter
  always_ff @(posedge clk) begin
    if (rst)                 hCount <= '0;
    else if (strobes.lineWrap) hCount <= '0;
    else if (strobes.pixEn)  hCount <= hCount + 1'b1;
  end

  // Line counter
  always_ff @(posedge clk) begin
    if (rst)                   lineNum <= '0;
    else if (strobes.frameWrap) lineNum <= '0;
    else if (strobes.lineWrap) lineNum <= lineNum + 1'b1;
  end

  // Mode register: loaded during reset and at each frame boundary
  always_ff @(posedge clk) begin
    if (rst || strobes.frameWrap) activeMode <= scanMode_t'(modeSel);
  end

  // Geometry of the frame in progress
  always_comb begin
    unique case (activeMode)
      MODE_SHORT: begin
        lastLine = B_LAST; visLines = B_VIS; vsFrom = B_VSA; vsTo = B_VSB;
        vsPolHigh = 1'b1;
      end
      default: begin
        lastLine = A_LAST; visLines = A_VIS; vsFrom = A_VSA; vsTo = A_VSB;
        vsPolHigh = 1'b0;
      end
    endcase
  end

  always_comb begin
    hAtEnd      = (hCount == H_LAST);
    vAtEnd      = (lineNum == lastLine);
    hsync       = !((hCount >= H_SYNC_A) && (hCount < H_SYNC_B));
    vsActive    = (lineNum >= vsFrom) && (lineNum < vsTo);
    vsync       = vsPolHigh ? vsActive : !vsActive;
    lineVisible = (lineNum < visLines);
  end
endmodule

// File: rtl/vgaSyncGen.sv
module vgaSyncGen
  import vgaSyncPkg::*;
#(
  parameter int DIV        = 4,
  parameter int H_TOTAL    = 800,
  parameter int HS_START   = 16,
  parameter int HS_END     = 48,
  parameter int A_VTOTAL   = 525,
  parameter int A_VISIBLE  = 480,
  parameter int A_VS_START = 490,
  parameter int A_VS_END   = 492,
  parameter int B_VTOTAL   = 445,
  parameter int B_VISIBLE  = 400,
  parameter int B_VS_START = 401,
  parameter int B_VS_END   = 404,
  parameter int LW         = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          modeSel,
  output logic          hsync,
  output logic          vsync,
  output logic          lineVisible,
  output logic [LW-1:0] lineNum,
  output logic          lineStart,
  output logic          frameStart
);
  localparam int HW = $clog2(H_TOTAL);

  timingStrobes_t strobes;
  logic [HW-1:0]  hCount;
  scanMode_t      activeMode;
  logic           hAtEnd, vAtEnd;

  vgaSyncCtrl #(.DIV(DIV)) ctrl_i (
    .clk(clk), .rst(rst), .hAtEnd(hAtEnd), .vAtEnd(vAtEnd), .strobes(strobes)
  );

  vgaSyncDatapath #(
    .H_TOTAL(H_TOTAL), .HS_START(HS_START), .HS_END(HS_END),
    .A_VTOTAL(A_VTOTAL), .A_VISIBLE(A_VISIBLE), .A_VS_START(A_VS_START), .A_VS_END(A_VS_END),
    .B_VTOTAL(B_VTOTAL), .B_VISIBLE(B_VISIBLE), .B_VS_START(B_VS_START), .B_VS_END(B_VS_END),
    .LW(LW)
  ) dp_i (
    .clk(clk), .rst(rst), .modeSel(modeSel), .strobes(strobes),
    .hCount(hCount), .lineNum(lineNum), .activeMode(activeMode),
    .hAtEnd(hAtEnd), .vAtEnd(vAtEnd),
    .hsync(hsync), .vsync(vsync), .lineVisible(lineVisible)
  );

  assign lineStart  = strobes.lineWrap;
  assign frameStart = strobes.frameWrap;
endmodule

// File: rtl/vgaSyncChecker.sv
module vgaSyncChecker #(
  parameter int DIV      = 4,
  parameter int H_TOTAL  = 800,
  parameter int HS_START = 16,
  parameter int HS_END   = 48,
  parameter int LW       = 10,
  parameter int HW       = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          lineStart,
  input logic          frameStart,
  input logic          hsync,
  input logic          lineVisible,
  input logic [LW-1:0] lineNum,
  input logic [HW-1:0] hCount,
  input logic          activeMode
);
  localparam int PERIOD = DIV * H_TOTAL;

  int unsigned gap;
  logic        seenLine;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap <= 0;
      seenLine <= 1'b0;
    end else if (lineStart) begin
      gap <= 0;
      seenLine <= 1'b1;
    end else begin
      gap <= gap + 1;
    end
  end

  assert_line_period_R1: assert property (@(posedge clk) disable iff (rst)
    (lineStart && seenLine) |-> (gap == PERIOD - 1));

  assert_hsync_edges_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(hsync) |-> (hCount == HW'(HS_START) || hCount == HW'(HS_END)));

  assert_frame_in_line_R7: assert property (@(posedge clk) disable iff (rst)
    frameStart |-> lineStart);

  assert_line_step_R7: assert property (@(posedge clk) disable iff (rst)
    (lineStart && !frameStart) |=> (lineNum == $past(lineNum) + 1'b1));

  assert_frame_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    frameStart |=> (lineNum == '0));

  assert_line_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !lineStart |=> $stable(lineNum));

  assert_mode_at_frame_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(activeMode) |-> $past(frameStart));

  assert_visible_rise_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(lineVisible) |-> (lineNum == '0));
endmodule

bind vgaSyncGen vgaSyncChecker #(
  .DIV(DIV), .H_TOTAL(H_TOTAL), .HS_START(HS_START), .HS_END(HS_END),
  .LW(LW), .HW($clog2(H_TOTAL))
) chk_i (
  .clk(clk), .rst(rst), .lineStart(lineStart), .frameStart(frameStart),
  .hsync(hsync), .lineVisible(lineVisible), .lineNum(lineNum),
  .hCount(hCount), .activeMode(activeMode)
);

// File: tb/vgaSyncGen_tb.sv
`timescale 1ns/1ps
module vgaSyncGen_tb_top;
  localparam int DIV = 2, HT = 20, HSA = 2, HSB = 6, LW = 4;
  localparam int AT = 12, AV = 8, AS = 9, AE = 11;
  localparam int BT = 10, BV = 6, BS = 7, BE = 9;

  logic clk = 1'b0, rst = 1'b1, modeSel = 1'b0;
  logic hsync, vsync, lineVisible, lineStart, frameStart;
  logic [LW-1:0] lineNum;

  int checks = 0, fails = 0;
  bit done = 0;
  int rDiv, rH, rV, rMode;

  always #4 clk = ~clk;

  vgaSyncGen #(
    .DIV(DIV), .H_TOTAL(HT), .HS_START(HSA), .HS_END(HSB),
    .A_VTOTAL(AT), .A_VISIBLE(AV), .A_VS_START(AS), .A_VS_END(AE),
    .B_VTOTAL(BT), .B_VISIBLE(BV), .B_VS_START(BS), .B_VS_END(BE), .LW(LW)
  ) dut_i (
    .clk(clk), .rst(rst), .modeSel(modeSel), .hsync(hsync), .vsync(vsync),
    .lineVisible(lineVisible), .lineNum(lineNum), .lineStart(lineStart),
    .frameStart(frameStart)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (h=%0d line=%0d)", req, act, exp, rH, rV);
    end
  endtask

  function automatic int vTot(input int m); return m ? BT : AT; endfunction

  task automatic checkNow();
    int pixEn, ls, fs, act;
    pixEn = (rDiv == DIV - 1);
    ls = pixEn && (rH == HT - 1);
    fs = ls && (rV == vTot(rMode) - 1);
    act = rMode ? (rV >= BS && rV < BE) : (rV >= AS && rV < AE);
    chk("R1/R6 lineStart", int'(lineStart), ls);
    chk("R2 hsync", int'(hsync), !(rH >= HSA && rH < HSB));
    chk("R7 lineNum", int'(lineNum), rV);
    chk("R7 frameStart", int'(frameStart), fs);
    chk("R3/R4/R5/R8 vsync", int'(vsync), rMode ? act : !act);
    chk("R10 lineVisible", int'(lineVisible), rV < (rMode ? BV : AV));
  endtask

  task automatic stepRef();
    int pixEn, ls, fs;
    pixEn = (rDiv == DIV - 1);
    ls = pixEn && (rH == HT - 1);
    fs = ls && (rV == vTot(rMode) - 1);
    rDiv = pixEn ? 0 : rDiv + 1;
    if (pixEn) rH = ls ? 0 : rH + 1;
    if (ls) rV = fs ? 0 : rV + 1;
    if (fs) rMode = int'(modeSel);
  endtask

  task automatic doReset(input logic m);
    @(negedge clk);
    rst = 1'b1;
    modeSel = m;
    repeat (3) @(negedge clk);
    chk("R9 lineNum", int'(lineNum), 0);
    chk("R9 lineStart", int'(lineStart), 0);
    chk("R9 frameStart", int'(frameStart), 0);
    chk("R9 hsync", int'(hsync), 1);
    chk("R9 vsync", int'(vsync), m ? 0 : 1);
    rDiv = 0; rH = 0; rV = 0; rMode = int'(m);
    rst = 1'b0;
  endtask

  // Run n cycles; at cycle swAt drive modeSel to newMode
  task automatic run(input int n, input int swAt, input logic newMode);
    for (int i = 0; i < n; i++) begin
      checkNow();
      if (i == swAt) modeSel = newMode;
      stepRef();
      @(negedge clk);
    end
  endtask

  initial begin
    // Mode 0: several frames, then a switch in mid-frame (R8)
    doReset(1'b0);
    run(3 * DIV * HT * AT, -1, 1'b0);
    run(3 * DIV * HT * BT + DIV * HT * AT, DIV * HT * 5, 1'b1);
    // Switch back one clock before the frame boundary
    run(4 * DIV * HT * AT, DIV * HT * BT - 2, 1'b0);
    // Reset in mode 1 (R9), then run and switch right at a boundary
    doReset(1'b1);
    run(3 * DIV * HT * BT, DIV * HT * BT - 1, 1'b0);
    run(2 * DIV * HT * AT, -1, 1'b0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule